// File: doc/BRIEF.md
# PHY Control Register Block with Aliased Bit Access

This block holds two 32-bit registers of a USB PHY: a general control register and a companion register for a false-disconnect suppression fix. Each register is reachable at four consecutive word addresses. One address replaces the whole word. The other three set, clear or invert only the bits written as 1. Software can therefore change a single bit without a read-modify-write sequence.

The control register contains a high-speed disconnect detector. The detector enable is at bit 1, and a sticky interrupt flag is at bit 3. A disconnect pulse counts only when the enable is on and the port runs in high-speed mode. A counted pulse trips an internal latch and raises the flag. A clear write removes the flag, but the latch puts it back on the next cycle. The latch releases only after the enable has been low for a cycle, and it re-arms when the enable goes high again.

The companion register has a read-only bit 16 that reports whether the fix is built in. Bits 17 and 18 are writable. When both are set, pulses that arrive while the suppression-window input is high are dropped. That input marks the early period after high-speed negotiation.

Top module: `phyCtrlRegs`

## Requirements
- R1: After reset the control register reads 0xC020_0040 and the companion register reads 0x0001_0000 when the fix is built in (bit 16 equals parameter FIX_PRESENT).
- R2: The word address is 4*r+k. r=0 selects the control register and r=1 selects the companion register. k=0 replaces the writable bits, k=1 ORs the write data in, k=2 clears the bits written as 1, and k=3 inverts the bits written as 1. All control bits except bit 3 are writable.
- R3: A disconnect pulse with control bit 1 high, hsMode high and no suppression sets control bit 3 and discIrq at the next clock edge.
- R4: Control bit 3 is not changed by writes at the replace, set or toggle addresses.
- R5: A write of 1 to bit 3 at the clear address (word 2) drops the flag at the next edge. While the detector latch is tripped, the flag returns one cycle later. The latch is released once bit 1 has been low for a cycle. After that a clear stays in effect, and setting bit 1 again re-arms detection.
- R6: Companion bit 16 is read-only and equals FIX_PRESENT. Bits 17 and 18 are writable through all four aliases. All other companion bits read 0.
- R7: Disconnect pulses are ignored while control bit 1 is low or hsMode is low.
- R8: When companion bits 17 and 18 are both 1, pulses arriving with suppressWin high are ignored. If either bit is 0, such pulses count.
- R9: A read at any of a register's four addresses returns that register's current value, and a read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for the addressed word |
| busAddr | input | 3 | Word address: register index at bit 2, alias at bits 1:0 |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Value of the addressed register |
| hsMode | input | 1 | Port is running in high-speed mode |
| discPulse | input | 1 | Raw disconnect-detect pulse |
| suppressWin | input | 1 | Early window after high-speed negotiation |
| discIrq | output | 1 | Disconnect interrupt flag (control bit 3) |

## Verification
The bench builds the block with its default parameters: FIX_PRESENT set and the control reset value 0xC020_0040. With these values, the read-only fix indicator and the suppression path can both be reached, so the bench can drive both fix enables through the aliases and test suppression with one enable and with both. The reset value has bits set in the upper half, so the first alias writes act on bits that are not zero.

// File: rtl/phyCtrlPkg.sv
package phyCtrlPkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 2;
  localparam int REG_CTRL = 0;
  localparam int REG_FIX  = 1;

  localparam int DET_EN_BIT   = 1;
  localparam int IRQ_BIT      = 3;
  localparam int FIX_ID_BIT   = 16;
  localparam int FIX_EN_A_BIT = 17;
  localparam int FIX_EN_B_BIT = 18;

  typedef enum logic [1:0] {
    ACC_REPLACE = 2'd0,
    ACC_SET     = 2'd1,
    ACC_CLEAR   = 2'd2,
    ACC_INVERT  = 2'd3
  } accessE;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    accessE              accKind;
    logic                irqSet;
    logic                irqClr;
  } strobeS;
endpackage

// File: rtl/phyCtrlCtl.sv
module phyCtrlCtl
  import phyCtrlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wdataIrqBit,
  input  logic              detEn,
  input  logic              fixBoth,
  input  logic              hsMode,
  input  logic              discPulse,
  input  logic              suppressWin,
  output strobeS            strb
);
  logic   tripped;
  logic   qualPulse;
  logic   regIdx;
  accessE accKind;

  assign regIdx    = busAddr[2];
  assign accKind   = accessE'(busAddr[1:0]);
  assign qualPulse = discPulse & detEn & hsMode & ~(fixBoth & suppressWin);

  // Detector latch: stays tripped until the enable is dropped.
  always_ff @(posedge clk) begin
    if (!rstN)       tripped <= 1'b0;
    else if (!detEn) tripped <= 1'b0;
    else             tripped <= tripped | qualPulse;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign strb.wrSel[g] = busWr && (regIdx == 1'(g));
  end

  assign strb.accKind = accKind;
  assign strb.irqSet  = tripped | qualPulse;
  assign strb.irqClr  = busWr && (regIdx == 1'(REG_CTRL)) &&
                        (accKind == ACC_CLEAR) && wdataIrqBit;
endmodule

// File: rtl/phyCtrlDp.sv
module phyCtrlDp
  import phyCtrlPkg::*;
#(
  parameter logic [DATA_W-1:0] CTRL_RESET  = 32'hC020_0040,
  parameter bit                FIX_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              detEn,
  output logic              fixBoth,
  output logic              irqFlag,
  output logic [DATA_W-1:0] ctrlVal,
  output logic [DATA_W-1:0] fixVal
);
  localparam logic [DATA_W-1:0] IRQ_MASK  = DATA_W'(1) << IRQ_BIT;
  localparam logic [DATA_W-1:0] CTRL_WMASK = ~IRQ_MASK;
  localparam logic [DATA_W-1:0] FIX_WMASK  = (DATA_W'(1) << FIX_EN_A_BIT) |
                                             (DATA_W'(1) << FIX_EN_B_BIT);
  localparam logic [DATA_W-1:0] FIX_RESET  = DATA_W'(FIX_PRESENT) << FIX_ID_BIT;

  function automatic logic [DATA_W-1:0] resetOf(input int idx);
    return (idx == REG_CTRL) ? (CTRL_RESET & CTRL_WMASK) : FIX_RESET;
  endfunction

  function automatic logic [DATA_W-1:0] maskOf(input int idx);
    return (idx == REG_CTRL) ? CTRL_WMASK : FIX_WMASK;
  endfunction

  function automatic logic [DATA_W-1:0] applyAccess(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] wd,
    input accessE            kind
  );
    case (kind)
      ACC_SET:    return cur | wd;
      ACC_CLEAR:  return cur & ~wd;
      ACC_INVERT: return cur ^ wd;
      default:    return wd;
    endcase
  endfunction

  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] regD [NUM_REGS];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      logic [DATA_W-1:0] cand;
      cand = strb.wrSel[i] ? applyAccess(regQ[i], busWdata, strb.accKind) : regQ[i];
      regD[i] = (cand & maskOf(i)) | (regQ[i] & ~maskOf(i));
      if (i == REG_CTRL)
        regD[i][IRQ_BIT] = strb.irqClr ? 1'b0 : (regQ[i][IRQ_BIT] | strb.irqSet);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN) regQ[i] <= resetOf(i);
      else       regQ[i] <= regD[i];
    end
  end

  assign busRdata = regQ[busAddr[2]];
  assign ctrlVal  = regQ[REG_CTRL];
  assign fixVal   = regQ[REG_FIX];
  assign detEn    = regQ[REG_CTRL][DET_EN_BIT];
  assign irqFlag  = regQ[REG_CTRL][IRQ_BIT];
  assign fixBoth  = regQ[REG_FIX][FIX_EN_A_BIT] & regQ[REG_FIX][FIX_EN_B_BIT];
endmodule

// File: rtl/phyCtrlRegs.sv
module phyCtrlRegs
  import phyCtrlPkg::*;
#(
  parameter logic [31:0] CTRL_RESET  = 32'hC020_0040,
  parameter bit          FIX_PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        hsMode,
  input  logic        discPulse,
  input  logic        suppressWin,
  output logic        discIrq
);
  strobeS            strb;
  logic              detEn;
  logic              fixBoth;
  logic [DATA_W-1:0] ctrlVal;
  logic [DATA_W-1:0] fixVal;

  phyCtrlCtl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .wdataIrqBit (busWdata[IRQ_BIT]),
    .detEn       (detEn),
    .fixBoth     (fixBoth),
    .hsMode      (hsMode),
    .discPulse   (discPulse),
    .suppressWin (suppressWin),
    .strb        (strb)
  );

  phyCtrlDp #(
    .CTRL_RESET  (CTRL_RESET),
    .FIX_PRESENT (FIX_PRESENT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .detEn    (detEn),
    .fixBoth  (fixBoth),
    .irqFlag  (discIrq),
    .ctrlVal  (ctrlVal),
    .fixVal   (fixVal)
  );
endmodule

// File: rtl/phyCtrlChk.sv
module phyCtrlChk #(
  parameter bit FIX_PRESENT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic [2:0]  busAddr,
  input logic [31:0] busWdata,
  input logic        discIrq,
  input logic [31:0] ctrlVal,
  input logic [31:0] fixVal
);
  // R5: a clear-alias write of bit 3 always drops the flag at the next edge
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd2 && busWdata[3]) |=> !discIrq);

  // R4: no other write can remove the flag
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (discIrq && !(busWr && busAddr == 3'd2 && busWdata[3])) |=> discIrq);

  // R7: with the detector off for two cycles, the flag cannot rise
  a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlVal[1] && !$past(ctrlVal[1]) && !discIrq) |=> !discIrq);

  // R6: companion register shape
  a_r6_fix_shape: assert property (@(posedge clk) disable iff (!rstN)
    (fixVal[16] == FIX_PRESENT) && ((fixVal & ~32'h0007_0000) == 32'h0));

  // R2: replace alias loads the writable control bits
  a_r2_replace: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd0) |=> ((ctrlVal & ~32'h8) == ($past(busWdata) & ~32'h8)));
endmodule

bind phyCtrlRegs phyCtrlChk #(.FIX_PRESENT(FIX_PRESENT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .discIrq  (discIrq),
  .ctrlVal  (ctrlVal),
  .fixVal   (fixVal)
);

// File: tb/phyCtrlRegs_tb.sv
module phyCtrlRegs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        hsMode = 1'b0;
  logic        discPulse = 1'b0;
  logic        suppressWin = 1'b0;
  logic        discIrq;

  int checks = 0;
  int failures = 0;
  logic rdStrobe = 1'b0;
  logic finished = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  phyCtrlRegs u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hsMode(hsMode),
    .discPulse(discPulse), .suppressWin(suppressWin), .discIrq(discIrq)
  );

  // Monitor: pops expected read values as reads happen
  always @(negedge clk) begin
    if (rdStrobe) begin
      logic [31:0] exp;
      string tag;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      checks++;
      if (busRdata !== exp) begin
        failures++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", tag, busAddr, busRdata, exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    busAddr = a; rdStrobe = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); #1;
    rdStrobe = 1'b0;
  endtask

  task automatic pulse();
    @(posedge clk); #1; discPulse = 1'b1;
    @(posedge clk); #1; discPulse = 1'b0;
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    checks++;
    if (discIrq !== exp) begin
      failures++;
      $display("FAIL %s discIrq actual=%b expected=%b", tag, discIrq, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset values, R9 all aliases read the same value
    rd(3'd0, 32'hC020_0040, "R1 ctrl reset");
    rd(3'd1, 32'hC020_0040, "R9 ctrl alias1 read");
    rd(3'd3, 32'hC020_0040, "R9 ctrl alias3 read");
    rd(3'd4, 32'h0001_0000, "R1 fix reset");
    chkIrq(1'b0, "R1 irq reset");
    // R2 alias writes
    wr(3'd0, 32'h1234_5678); rd(3'd0, 32'h1234_5670, "R2 replace");
    wr(3'd1, 32'h0000_0001); rd(3'd0, 32'h1234_5671, "R2 set");
    wr(3'd2, 32'h0000_0070); rd(3'd0, 32'h1234_5601, "R2 clear");
    wr(3'd3, 32'h0000_FF00); rd(3'd0, 32'h1234_A901, "R2 toggle");
    wr(3'd0, 32'h0);         rd(3'd0, 32'h0, "R2 replace zero");
    // R7 enable off / hsMode off
    hsMode = 1'b1; pulse(); rd(3'd0, 32'h0, "R7 enable low");
    wr(3'd0, 32'h2); hsMode = 1'b0; pulse(); rd(3'd0, 32'h2, "R7 hsMode low");
    chkIrq(1'b0, "R7 irq quiet");
    // R4 set/toggle cannot touch bit 3
    wr(3'd1, 32'h8); rd(3'd0, 32'h2, "R4 set ignored");
    wr(3'd3, 32'h8); rd(3'd0, 32'h2, "R4 toggle ignored");
    // R6 companion
    wr(3'd5, 32'h0006_0000); rd(3'd4, 32'h0007_0000, "R6 fix set");
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd6, 32'h0007_0000, "R6 fix replace");
    // R8 suppression with both enables
    hsMode = 1'b1; suppressWin = 1'b1; pulse(); rd(3'd0, 32'h2, "R8 suppressed");
    wr(3'd6, 32'h0002_0000); rd(3'd4, 32'h0005_0000, "R6 fix clear");
    pulse(); rd(3'd0, 32'hA, "R8 one enable counts");
    chkIrq(1'b1, "R3 irq raised");
    suppressWin = 1'b0;
    // R4 replace does not clear
    wr(3'd0, 32'h2); rd(3'd0, 32'hA, "R4 replace ignored");
    // R5 clear while tripped reasserts; release by disable
    wr(3'd2, 32'h8); rd(3'd0, 32'hA, "R5 reassert while tripped");
    wr(3'd2, 32'h2); rd(3'd0, 32'h8, "R5 disable keeps flag");
    wr(3'd2, 32'h8); rd(3'd0, 32'h0, "R5 clear sticks");
    chkIrq(1'b0, "R5 irq cleared");
    wr(3'd1, 32'h2); rd(3'd0, 32'h2, "R5 re-enable");
    pulse(); rd(3'd0, 32'hA, "R3 re-armed trip");
    chkIrq(1'b1, "R3 irq after rearm");
    rd(3'd2, 32'hA, "R9 ctrl alias2 read");
    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      checks++; failures++;
      $display("FAIL R9 pending reads actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule